// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that completes every instruction in one clock cycle. It supports six instructions: unsigned add, unsigned subtract, OR with an immediate, load word, store word, and branch-if-equal. Within one cycle it fetches a word from a small internal instruction store, decodes the fields, reads two registers, computes a result in the ALU, and optionally touches a small internal data store. At the closing rising edge it writes the register file and the program counter. Any encoding outside the six leaves all state alone except the PC, which steps to the next word.

A control unit turns the opcode and function fields into a compact bundle of strobes that steers the datapath multiplexers. The datapath holds the PC, the register file, the ALU, the extension logic, branch-target arithmetic and both word stores. The instruction store is filled through a write port, normally while reset is held. Two combinational debug read ports expose any register and any data word, so the architectural state can be observed from outside.

Top module: `lite_cpu_core`

## Requirements
- R1: While reset (rst, synchronous, active high) is sampled high at a rising edge, the PC becomes 0 and every register and data word becomes 0; the instruction store keeps its contents.
- R2: The instruction executed is the instruction-store word at index PC[IAW+1:2], with IAW = log2(IMEM_WORDS). Every instruction other than a taken branch sets PC to PC + 4 at the edge.
- R3: R-type words (op bits [31:26] = 0x00) with funct bits [5:0] = 0x21 write R[rd] = R[rs] + R[rt], and with funct = 0x23 write R[rd] = R[rs] - R[rt], both modulo 2^32. rs is bits [25:21], rt is bits [20:16], and rd is bits [15:11].
- R4: op = 0x0D writes R[rt] = R[rs] OR {16'h0, imm16}, where imm16 is bits [15:0] (zero extension).
- R5: op = 0x23 writes R[rt] = data word at index A[DAW+1:2], where A = R[rs] + sign-extended imm16 and DAW = log2(DMEM_WORDS).
- R6: op = 0x2B stores R[rt] into the data word at index A[DAW+1:2], with A formed as in R5, and writes no register.
- R7: op = 0x04 sets PC = PC + 4 + (sign-extended imm16 << 2) when R[rs] equals R[rt], and PC = PC + 4 otherwise. It writes no register and no data word.
- R8: Register 0 always reads as 0. Writes addressed to it are discarded.
- R9: Any other opcode, and any R-type funct other than 0x21 or 0x23, changes no register and no data word and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imemWrEn | input | 1 | Write strobe for the instruction store |
| imemWrAddr | input | IAW | Word index written in the instruction store |
| imemWrData | input | 32 | Instruction word to write |
| pcOut | output | 32 | Current program counter |
| dbgRegSel | input | 5 | Register selected for the debug read |
| dbgRegData | output | 32 | Combinational value of the selected register |
| dbgMemSel | input | DAW | Data word selected for the debug read |
| dbgMemData | output | 32 | Combinational value of the selected data word |

## Verification
Every architectural effect of an instruction (register write, data-word store, next PC) appears after the single rising edge that ends that instruction's cycle. Both debug reads are combinational, so that state is visible in the following low phase. The bench steps an instruction-level model once for each clock edge. It then compares the PC, one register and one data word at the falling edge after that rising edge. Every comparison is therefore made against the state that exactly one instruction produced. Reset-state sweeps happen while reset is still held, and the directed program's final values are read once its closing self-branch is spinning.

// File: rtl/lite_cpu_pkg.sv
package lite_cpu_pkg;

  localparam int XLEN      = 32;
  localparam int REG_COUNT = 32;
  localparam int RAW       = $clog2(REG_COUNT);

  // Instruction encodings decoded by the control unit
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } aluOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   regWrite;  // write the register file this cycle
    logic   dstIsRd;   // destination is rd (else rt)
    logic   srcIsImm;  // ALU operand B is the extended immediate
    logic   zeroExt;   // immediate is zero-extended (else sign-extended)
    aluOp_e aluOp;
    logic   memWrite;  // store rt into data memory
    logic   loadSel;   // write-back takes the data-memory word
    logic   branch;    // conditional branch on ALU equality
  } ctlStrobe_t;

endpackage

// File: rtl/lite_cpu_alu.sv
module lite_cpu_alu
  import lite_cpu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluOp_e       op,
  output logic [W-1:0] result,
  output logic         isZero
);

  always_comb begin
    unique case (op)
      ALU_SUB: result = opA - opB;
      ALU_OR:  result = opA | opB;
      default: result = opA + opB;
    endcase
  end

  assign isZero = (result == '0);

endmodule

// File: rtl/lite_cpu_regfile.sv
module lite_cpu_regfile
  import lite_cpu_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int DEPTH = REG_COUNT,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  input  logic [AW-1:0] rdAddrC,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB,
  output logic [W-1:0]  rdDataC,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);

  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
  assign rdDataC = (rdAddrC == '0) ? '0 : regs[rdAddrC];

endmodule

// File: rtl/lite_cpu_ctrl.sv
module lite_cpu_ctrl
  import lite_cpu_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  output ctlStrobe_t  ctl
);

  always_comb begin
    ctl       = '0;
    ctl.aluOp = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADDU) begin
          ctl.regWrite = 1'b1;
          ctl.dstIsRd  = 1'b1;
        end else if (funct == FN_SUBU) begin
          ctl.regWrite = 1'b1;
          ctl.dstIsRd  = 1'b1;
          ctl.aluOp    = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctl.regWrite = 1'b1;
        ctl.srcIsImm = 1'b1;
        ctl.zeroExt  = 1'b1;
        ctl.aluOp    = ALU_OR;
      end
      OP_LW: begin
        ctl.regWrite = 1'b1;
        ctl.srcIsImm = 1'b1;
        ctl.loadSel  = 1'b1;
      end
      OP_SW: begin
        ctl.srcIsImm = 1'b1;
        ctl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.aluOp  = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lite_cpu_dpath.sv
module lite_cpu_dpath
  import lite_cpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobe_t       ctl,
  input  logic             imemWrEn,
  input  logic [IAW-1:0]   imemWrAddr,
  input  logic [XLEN-1:0]  imemWrData,
  input  logic [RAW-1:0]   dbgRegSel,
  output logic [XLEN-1:0]  dbgRegData,
  input  logic [DAW-1:0]   dbgMemSel,
  output logic [XLEN-1:0]  dbgMemData,
  output logic [XLEN-1:0]  pcOut,
  output logic [XLEN-1:0]  instrWord,
  output logic [XLEN-1:0]  rsValue,
  output logic             aluEqual
);

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] pcPlus4;
  logic [XLEN-1:0] brTarget;
  logic [XLEN-1:0] pcNext;
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [RAW-1:0]  rsIdx, rtIdx, rdIdx, dstIdx;
  logic [15:0]     imm16;
  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] rsData, rtData;
  logic [XLEN-1:0] aluB, aluY;
  logic [DAW-1:0]  memIdx;
  logic [XLEN-1:0] memRdData;
  logic [XLEN-1:0] wbData;

  // Fetch
  always_ff @(posedge clk) begin
    if (imemWrEn) imem[imemWrAddr] <= imemWrData;
  end

  assign instrWord = imem[pc[IAW+1:2]];

  // Decode
  assign rsIdx  = instrWord[25:21];
  assign rtIdx  = instrWord[20:16];
  assign rdIdx  = instrWord[15:11];
  assign imm16  = instrWord[15:0];
  assign immExt = ctl.zeroExt ? {16'h0000, imm16} : {{16{imm16[15]}}, imm16};
  assign dstIdx = ctl.dstIsRd ? rdIdx : rtIdx;

  lite_cpu_regfile #(
    .W     (XLEN),
    .DEPTH (REG_COUNT)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .rdAddrC (dbgRegSel),
    .rdDataA (rsData),
    .rdDataB (rtData),
    .rdDataC (dbgRegData),
    .wrEn    (ctl.regWrite),
    .wrAddr  (dstIdx),
    .wrData  (wbData)
  );

  // Execute
  assign aluB = ctl.srcIsImm ? immExt : rtData;

  lite_cpu_alu #(
    .W (XLEN)
  ) u_alu (
    .opA    (rsData),
    .opB    (aluB),
    .op     (ctl.aluOp),
    .result (aluY),
    .isZero (aluEqual)
  );

  // Memory
  assign memIdx    = aluY[DAW+1:2];
  assign memRdData = dmem[memIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
    end else if (ctl.memWrite) begin
      dmem[memIdx] <= rtData;
    end
  end

  assign dbgMemData = dmem[dbgMemSel];

  // Write-back select
  assign wbData = ctl.loadSel ? memRdData : aluY;

  // Next PC
  assign pcPlus4  = pc + 32'd4;
  assign brTarget = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign pcNext   = (ctl.branch && aluEqual) ? brTarget : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign pcOut   = pc;
  assign rsValue = rsData;

endmodule

// File: rtl/lite_cpu_core.sv
module lite_cpu_core
  import lite_cpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imemWrEn,
  input  logic [IAW-1:0]  imemWrAddr,
  input  logic [31:0]     imemWrData,
  output logic [31:0]     pcOut,
  input  logic [4:0]      dbgRegSel,
  output logic [31:0]     dbgRegData,
  input  logic [DAW-1:0]  dbgMemSel,
  output logic [31:0]     dbgMemData
);

  ctlStrobe_t      ctlBus;
  logic [XLEN-1:0] instrWord;
  logic [XLEN-1:0] rsValue;
  logic            aluEqual;

  lite_cpu_ctrl u_ctrl (
    .opcode (instrWord[31:26]),
    .funct  (instrWord[5:0]),
    .ctl    (ctlBus)
  );

  lite_cpu_dpath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctlBus),
    .imemWrEn   (imemWrEn),
    .imemWrAddr (imemWrAddr),
    .imemWrData (imemWrData),
    .dbgRegSel  (dbgRegSel),
    .dbgRegData (dbgRegData),
    .dbgMemSel  (dbgMemSel),
    .dbgMemData (dbgMemData),
    .pcOut      (pcOut),
    .instrWord  (instrWord),
    .rsValue    (rsValue),
    .aluEqual   (aluEqual)
  );

endmodule

// File: rtl/lite_cpu_chk.sv
module lite_cpu_chk
  import lite_cpu_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pcOut,
  input logic [XLEN-1:0] instr,
  input ctlStrobe_t      ctl,
  input logic            aluEq,
  input logic [XLEN-1:0] rsVal
);

  // R1: the edge that samples reset leaves the PC at zero
  a_r1_pc_reset: assert property (@(posedge clk) rst |=> (pcOut == '0));

  // R2: without a taken branch the PC steps by one word
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    !(ctl.branch && aluEq) |=> (pcOut == $past(pcOut) + 32'd4));

  // R7: a taken branch lands on PC + 4 + sign-extended offset * 4
  a_r7_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch && aluEq) |=>
      (pcOut == $past(pcOut) + 32'd4 +
                {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

  // R6: a store, a register write and a branch never share a cycle
  a_r6_one_effect: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.regWrite, ctl.memWrite, ctl.branch}));

  // R8: the rs read port returns zero for register 0
  a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> (rsVal == '0));

endmodule

bind lite_cpu_core lite_cpu_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .pcOut (pcOut),
  .instr (instrWord),
  .ctl   (ctlBus),
  .aluEq (aluEqual),
  .rsVal (rsValue)
);

// File: tb/lite_cpu_core_tb.sv
module lite_cpu_core_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int IW  = 64;
  localparam int DW  = 64;
  localparam int IAW = $clog2(IW);
  localparam int DAW = $clog2(DW);

  localparam logic [5:0] C_RT = 6'h00, C_ORI = 6'h0D, C_LW = 6'h23,
                         C_SW = 6'h2B, C_BEQ = 6'h04;
  localparam logic [5:0] F_ADD = 6'h21, F_SUB = 6'h23;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            imemWrEn = 1'b0;
  logic [IAW-1:0]  imemWrAddr = '0;
  logic [31:0]     imemWrData = '0;
  logic [31:0]     pcOut;
  logic [4:0]      dbgRegSel = '0;
  logic [31:0]     dbgRegData;
  logic [DAW-1:0]  dbgMemSel = '0;
  logic [31:0]     dbgMemData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [31:0] mImem [IW];
  logic [31:0] mReg  [32];
  logic [31:0] mMem  [DW];
  logic [31:0] mPc;
  int          lastMemIdx;

  always #10 clk = ~clk;  // 20 ns period

  lite_cpu_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_dut (
    .clk(clk), .rst(rst), .imemWrEn(imemWrEn), .imemWrAddr(imemWrAddr),
    .imemWrData(imemWrData), .pcOut(pcOut), .dbgRegSel(dbgRegSel),
    .dbgRegData(dbgRegData), .dbgMemSel(dbgMemSel), .dbgMemData(dbgMemData)
  );

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {C_RT, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] sext(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] randInstr();
    int kind = $urandom_range(0, 7);
    int rs = $urandom_range(0, 7);
    int rt = $urandom_range(0, 7);
    int rd = $urandom_range(0, 7);
    logic [15:0] off = 16'($urandom_range(0, 511) - 256);
    logic [5:0]  fn;
    case (kind)
      0: return encR(rs, rt, rd, F_ADD);
      1: return encR(rs, rt, rd, F_SUB);
      2, 3: return encI(C_ORI, rs, rt, 16'($urandom()));
      4: return encI(C_LW, rs, rt, off);
      5: return encI(C_SW, rs, rt, off);
      6: return encI(C_BEQ, rs, rt, 16'($urandom_range(0, 10) - 4));
      default: begin
        if ($urandom_range(0, 1) == 1) begin
          fn = 6'($urandom());
          if (fn == F_ADD || fn == F_SUB) fn = 6'h20;
          return encR(rs, rt, rd, fn);
        end
        return encI(6'h08, rs, rt, 16'($urandom()));
      end
    endcase
  endfunction

  // Instruction-level reference: applies one instruction, returns its requirement tag
  task automatic modelStep(output string tag);
    logic [31:0] ins, sx, zx, addr;
    logic [5:0]  op, fn;
    int rs, rt, rd;
    ins = mImem[mPc[IAW+1:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    sx = sext(ins[15:0]); zx = {16'h0, ins[15:0]};
    addr = mReg[rs] + sx;
    tag = "R2";
    case (op)
      C_RT: begin
        if (fn == F_ADD) begin
          if (rd != 0) mReg[rd] = mReg[rs] + mReg[rt];
          tag = (rd == 0) ? "R8" : "R3";
        end else if (fn == F_SUB) begin
          if (rd != 0) mReg[rd] = mReg[rs] - mReg[rt];
          tag = (rd == 0) ? "R8" : "R3";
        end else tag = "R9";
        mPc = mPc + 4;
      end
      C_ORI: begin
        if (rt != 0) mReg[rt] = mReg[rs] | zx;
        tag = (rt == 0) ? "R8" : "R4";
        mPc = mPc + 4;
      end
      C_LW: begin
        if (rt != 0) mReg[rt] = mMem[addr[DAW+1:2]];
        tag = (rt == 0) ? "R8" : "R5";
        mPc = mPc + 4;
      end
      C_SW: begin
        mMem[addr[DAW+1:2]] = mReg[rt];
        lastMemIdx = int'(addr[DAW+1:2]);
        tag = "R6";
        mPc = mPc + 4;
      end
      C_BEQ: begin
        if (mReg[rs] == mReg[rt]) mPc = mPc + 4 + {sx[29:0], 2'b00};
        else mPc = mPc + 4;
        tag = "R7";
      end
      default: begin
        tag = "R9";
        mPc = mPc + 4;
      end
    endcase
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Load the store under reset, clear the model, and sweep the reset state (R1)
  task automatic loadAndReset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < IW; i++) begin
      imemWrEn = 1'b1; imemWrAddr = IAW'(i); imemWrData = mImem[i];
      @(negedge clk);
    end
    imemWrEn = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 32; i++) mReg[i] = '0;
    for (int i = 0; i < DW; i++) mMem[i] = '0;
    mPc = '0;
    lastMemIdx = 0;
    check("R1", "pc after reset", pcOut, 32'h0);
    for (int i = 0; i < 8; i++) begin
      dbgRegSel = 5'(i * 4 + 3); dbgMemSel = DAW'(i * 8 + 5);
      #1;
      check("R1", "reg after reset", dbgRegData, 32'h0);
      check("R1", "mem after reset", dbgMemData, 32'h0);
    end
    rst = 1'b0;
  endtask

  // Lockstep run: compare, step model, take one edge
  task automatic runLockstep(int cycles);
    string tag, prevTag;
    prevTag = "R1";
    for (int c = 0; c < cycles; c++) begin
      dbgRegSel = 5'($urandom_range(0, 7));
      dbgMemSel = ($urandom_range(0, 1) == 1) ? DAW'(lastMemIdx) : DAW'($urandom_range(0, DW - 1));
      #1;
      check(prevTag, "pc", pcOut, mPc);
      check(prevTag, "reg", dbgRegData, mReg[dbgRegSel]);
      check(prevTag, "mem", dbgMemData, mMem[dbgMemSel]);
      modelStep(tag);
      prevTag = tag;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic peekReg(string tag, int r, logic [31:0] exp);
    dbgRegSel = 5'(r); #1;
    check(tag, "directed reg", dbgRegData, exp);
  endtask

  initial begin
    void'($urandom(32'd24681));

    // Directed program
    for (int i = 0; i < IW; i++) mImem[i] = 32'h0;
    mImem[0]  = encI(C_ORI, 0, 1, 16'h8005);
    mImem[1]  = encI(C_ORI, 0, 2, 16'h0003);
    mImem[2]  = encR(1, 2, 3, F_ADD);
    mImem[3]  = encR(2, 1, 4, F_SUB);
    mImem[4]  = encI(C_SW, 2, 3, 16'hFFFC);
    mImem[5]  = encI(C_LW, 2, 5, 16'hFFFC);
    mImem[6]  = encI(C_ORI, 1, 0, 16'hFFFF);
    mImem[7]  = encI(C_BEQ, 3, 5, 16'h0002);
    mImem[8]  = encI(C_ORI, 0, 6, 16'h0001);
    mImem[9]  = encI(C_ORI, 0, 6, 16'h0002);
    mImem[10] = encI(C_BEQ, 1, 2, 16'h0005);
    mImem[11] = encR(1, 2, 7, 6'h20);
    mImem[12] = encI(6'h08, 0, 7, 16'h1234);
    mImem[13] = encI(C_ORI, 0, 7, 16'h0055);
    mImem[14] = encI(C_BEQ, 0, 0, 16'hFFFF);
    loadAndReset();
    runLockstep(20);

    check("R7", "pc at self-branch", pcOut, 32'd56);
    peekReg("R4", 1, 32'h0000_8005);   // zero-extended OR immediate
    peekReg("R3", 3, 32'h0000_8008);   // 0x8005 + 3
    peekReg("R3", 4, 32'hFFFF_7FFE);   // 3 - 0x8005 wraps
    peekReg("R5", 5, 32'h0000_8008);   // load from 3 + (-4)
    peekReg("R8", 0, 32'h0);           // write to r0 discarded
    peekReg("R7", 6, 32'h0);           // taken branch skipped both writes
    peekReg("R9", 7, 32'h0000_0055);   // unsupported words left r7 for ORI
    dbgMemSel = DAW'(DW - 1); #1;
    check("R6", "store to word -1 wraps to top index", dbgMemData, 32'h0000_8008);
    @(negedge clk);

    // Random programs
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < IW; i++) mImem[i] = randInstr();
      loadAndReset();
      runLockstep(400);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule